// File: doc/BRIEF.md
# Nested Prioritized Interrupt Controller

This block gathers up to twenty level-sensitive interrupt lines and sorts each one into one of two request classes: a normal class and a fast class. Every line carries a three-bit priority, an enable bit and a class bit. For each class the block raises a request output whenever a qualifying line is active, and it presents a 32-bit vector word that identifies the winning line together with a software-supplied base value.

A control register turns on nesting separately for each class. With nesting off, a class simply reports its lowest-numbered active line and priorities play no part. With nesting on, a read of the class's vector word marks the winner's priority level in an eight-bit level stack. A marked level shuts out that level and every less urgent level. The handler later releases levels one at a time by writing the stack register. Each write clears only the most urgent marked level, so nested handlers unwind in strict order.

Top module: `nest_intc`

## Requirements
- R1: The control register resets to 0. A write through `ctl_we` loads `ctl_wdata`. Bit 0 turns on nesting for the normal class and bit 1 turns it on for the fast class.
- R2: The request for a class (`req[0]` normal, `req[1]` fast) is high exactly when some line is high, has its `src_en` bit set, has its `src_fast` bit equal to the class, and is not shut out by that class's stack. A line whose enable bit is 0 takes no part.
- R3: When nesting is off for a class, the vector names the lowest-numbered qualifying line, whatever the priorities are.
- R4: When nesting is on, the vector names the qualifying line with the smallest priority number. A tie at the same priority goes to the lowest line number.
- R5: A vector read strobe (`vec_rd[c]`) with nesting on and a request pending sets stack bit n, where n is the winner's priority, on the next clock edge. With nesting off, a read leaves the stack unchanged.
- R6: When nesting is on and any stack bit k is set, lines of the class whose priority is k or greater are shut out.
- R7: A write strobe (`stk_wr[c]`) clears only the lowest-numbered set stack bit; for example 0x09 becomes 0x08 and then 0x00. When a write and a pushing read fall in the same cycle, the pop acts on the old value and the push is then applied.
- R8: The vector word holds 0 in bits 1:0, the winning line number in bits 6:2 (line 8 reads as 01000), `base_val` in bits 22:7, and 0 in bits 31:23.
- R9: Each class has its own stack and its own vector. Reads, writes and masking in one class leave the other class's stack and request unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_lvl | input | 20 | Interrupt lines, level sensitive |
| src_en | input | 20 | Per-line enable |
| src_fast | input | 20 | Per-line class select: 1 = fast, 0 = normal |
| src_prio | input | 60 | Three-bit priority per line; line i uses bits 3i+2:3i |
| base_val | input | 16 | Base value placed into both vectors |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Control register write data |
| vec_rd | input | 2 | Vector read strobe per class (bit 0 normal, bit 1 fast) |
| stk_wr | input | 2 | Stack write strobe per class |
| ctrl_q | output | 2 | Control register value |
| req | output | 2 | Request per class |
| irq_vec | output | 32 | Normal-class vector word |
| fiq_vec | output | 32 | Fast-class vector word |
| irq_stack | output | 8 | Normal-class level stack |
| fiq_stack | output | 8 | Fast-class level stack |

## Verification
The requests and vector words are combinational, so they are due in the same cycle as a change to the lines, enables, priorities or stack. The bench drives these inputs on a falling edge and checks them 2 ns later, with no clock edge in between. The control register and both stacks change on the rising edge that sees a strobe. For these, the bench raises the strobe on a falling edge, drops it on the next falling edge, and then checks the stack, control value and the requests that depend on them. Any result that follows from a stack change is therefore read one edge after the strobe.

// File: rtl/nest_intc_pkg.sv
package nest_intc_pkg;
  localparam int PRIO_W    = 3;
  localparam int LVL_N     = 1 << PRIO_W;
  localparam int VIDX_W    = 5;
  localparam int BASE_W    = 16;
  localparam int WORD_W    = 32;
  localparam int CLASS_N   = 2;

  typedef enum logic {CLS_NORMAL = 1'b0, CLS_FAST = 1'b1} cls_e;

  // Remove the most urgent (lowest-numbered) marked level.
  function automatic logic [LVL_N-1:0] pop_top(input logic [LVL_N-1:0] s);
    return s & (s - 1'b1);
  endfunction

  // One-hot level bit for a priority.
  function automatic logic [LVL_N-1:0] lvl_bit(input logic [PRIO_W-1:0] p);
    logic [LVL_N-1:0] r;
    r = '0;
    r[p] = 1'b1;
    return r;
  endfunction

  // True when any marked level is as urgent as or more urgent than p.
  function automatic logic level_blocked(input logic [LVL_N-1:0] s,
                                         input logic [PRIO_W-1:0] p);
    logic hit;
    hit = 1'b0;
    for (int k = 0; k < LVL_N; k++) begin
      if (k <= int'(p) && s[k]) hit = 1'b1;
    end
    return hit;
  endfunction

  // Assemble a vector word from base and winner number.
  function automatic logic [WORD_W-1:0] make_vec(input logic [BASE_W-1:0] b,
                                                 input logic [VIDX_W-1:0] idx);
    logic [WORD_W-1:0] w;
    w = '0;
    w[VIDX_W+1:2] = idx;
    w[BASE_W+VIDX_W+1:VIDX_W+2] = b;
    return w;
  endfunction
endpackage

// File: rtl/nest_intc_ctrl.sv
module nest_intc_ctrl #(
  parameter int CLS_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CLS_N-1:0] wdata,
  output logic [CLS_N-1:0] nest_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  nest_en <= '0;
    else if (we) nest_en <= wdata;
  end
endmodule

// File: rtl/nest_intc_stack.sv
module nest_intc_stack
  import nest_intc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop,
  input  logic              push,
  input  logic [PRIO_W-1:0] push_lvl,
  output logic [LVL_N-1:0]  stk
);
  logic [LVL_N-1:0] after_pop;

  always_comb begin
    after_pop = pop ? pop_top(stk) : stk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    stk <= '0;
    else if (push) stk <= after_pop | lvl_bit(push_lvl);
    else           stk <= after_pop;
  end
endmodule

// File: rtl/nest_intc_arb.sv
module nest_intc_arb
  import nest_intc_pkg::*;
#(
  parameter int NUM_SRC = 20,
  parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0]        act,
  input  logic [NUM_SRC*PRIO_W-1:0] prio,
  input  logic                      use_prio,
  output logic                      found,
  output logic [IDX_W-1:0]          win_idx,
  output logic [PRIO_W-1:0]         win_prio
);
  always_comb begin
    found    = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (act[i]) begin
        if (!found || (use_prio && prio[i*PRIO_W +: PRIO_W] < win_prio)) begin
          found    = 1'b1;
          win_idx  = IDX_W'(i);
          win_prio = prio[i*PRIO_W +: PRIO_W];
        end
      end
    end
  end
endmodule

// File: rtl/nest_intc.sv
module nest_intc
  import nest_intc_pkg::*;
#(
  parameter int NUM_SRC = 20,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        src_lvl,
  input  logic [NUM_SRC-1:0]        src_en,
  input  logic [NUM_SRC-1:0]        src_fast,
  input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
  input  logic [BASE_W-1:0]         base_val,
  input  logic                      ctl_we,
  input  logic [CLASS_N-1:0]        ctl_wdata,
  input  logic [CLASS_N-1:0]        vec_rd,
  input  logic [CLASS_N-1:0]        stk_wr,
  output logic [CLASS_N-1:0]        ctrl_q,
  output logic [CLASS_N-1:0]        req,
  output logic [WORD_W-1:0]         irq_vec,
  output logic [WORD_W-1:0]         fiq_vec,
  output logic [LVL_N-1:0]          irq_stack,
  output logic [LVL_N-1:0]          fiq_stack
);
  // Named internal events, brought out for the checker.
  logic [CLASS_N-1:0]              nest;
  logic [CLASS_N-1:0]              found;
  logic [CLASS_N-1:0]              push_ev;
  logic [CLASS_N-1:0][IDX_W-1:0]   win_idx;
  logic [CLASS_N-1:0][PRIO_W-1:0]  win_prio;
  logic [CLASS_N-1:0][LVL_N-1:0]   stk;
  logic [CLASS_N-1:0][NUM_SRC-1:0] act;
  logic [CLASS_N-1:0][WORD_W-1:0]  vec;

  nest_intc_ctrl #(.CLS_N(CLASS_N)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (ctl_we),
    .wdata   (ctl_wdata),
    .nest_en (nest)
  );

  for (genvar c = 0; c < CLASS_N; c++) begin : g_cls
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign act[c][i] = src_lvl[i] && src_en[i] && (src_fast[i] == c[0]) &&
                         !(nest[c] && level_blocked(stk[c], src_prio[i*PRIO_W +: PRIO_W]));
    end

    nest_intc_arb #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
      .act      (act[c]),
      .prio     (src_prio),
      .use_prio (nest[c]),
      .found    (found[c]),
      .win_idx  (win_idx[c]),
      .win_prio (win_prio[c])
    );

    assign push_ev[c] = vec_rd[c] && nest[c] && found[c];

    nest_intc_stack u_stk (
      .clk      (clk),
      .rst_n    (rst_n),
      .pop      (stk_wr[c]),
      .push     (push_ev[c]),
      .push_lvl (win_prio[c]),
      .stk      (stk[c])
    );

    assign vec[c] = make_vec(base_val, VIDX_W'(win_idx[c]));
  end

  assign ctrl_q    = nest;
  assign req       = found;
  assign irq_vec   = vec[CLS_NORMAL];
  assign fiq_vec   = vec[CLS_FAST];
  assign irq_stack = stk[CLS_NORMAL];
  assign fiq_stack = stk[CLS_FAST];
endmodule

// File: rtl/nest_intc_chk.sv
module nest_intc_chk
  import nest_intc_pkg::*;
#(
  parameter int NUM_SRC = 20,
  parameter int IDX_W   = 5
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [NUM_SRC-1:0]                src_lvl,
  input logic [NUM_SRC-1:0]                src_en,
  input logic [NUM_SRC-1:0]                src_fast,
  input logic [CLASS_N-1:0]                vec_rd,
  input logic [CLASS_N-1:0]                stk_wr,
  input logic [CLASS_N-1:0]                req,
  input logic [CLASS_N-1:0]                nest,
  input logic [CLASS_N-1:0]                push_ev,
  input logic [CLASS_N-1:0][IDX_W-1:0]     win_idx,
  input logic [CLASS_N-1:0][PRIO_W-1:0]    win_prio,
  input logic [CLASS_N-1:0][LVL_N-1:0]     stk
);
  for (genvar c = 0; c < CLASS_N; c++) begin : g_chk
    AST_WINNER_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      req[c] |-> (src_lvl[win_idx[c]] && src_en[win_idx[c]] && src_fast[win_idx[c]] == c[0])); // R2
    AST_PUSH_MARKS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      push_ev[c] |=> stk[c][$past(win_prio[c])]); // R5
    AST_FLAT_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_rd[c] && !nest[c] && !stk_wr[c]) |=> $stable(stk[c])); // R5
    AST_WINNER_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (req[c] && nest[c]) |-> !level_blocked(stk[c], win_prio[c])); // R6
    AST_POP_SINGLE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_wr[c] && !push_ev[c] && stk[c] != '0) |=>
        ($countones(stk[c]) == $countones($past(stk[c])) - 1)); // R7
  end
endmodule

bind nest_intc nest_intc_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .src_lvl  (src_lvl),
  .src_en   (src_en),
  .src_fast (src_fast),
  .vec_rd   (vec_rd),
  .stk_wr   (stk_wr),
  .req      (req),
  .nest     (nest),
  .push_ev  (push_ev),
  .win_idx  (win_idx),
  .win_prio (win_prio),
  .stk      (stk)
);

// File: tb/nest_intc_bench.sv
module nest_intc_bench;
  localparam int NS = 20;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src_lvl = '0;
  logic [NS-1:0] src_en = '1;
  logic [NS-1:0] src_fast = '0;
  logic [NS*PW-1:0] src_prio = '1;
  logic [15:0]   base_val = 16'hA5C3;
  logic          ctl_we = 1'b0;
  logic [1:0]    ctl_wdata = '0;
  logic [1:0]    vec_rd = '0;
  logic [1:0]    stk_wr = '0;
  logic [1:0]    ctrl_q, req;
  logic [31:0]   irq_vec, fiq_vec;
  logic [7:0]    irq_stack, fiq_stack;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  nest_intc u_nest_intc (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .src_en(src_en),
    .src_fast(src_fast), .src_prio(src_prio), .base_val(base_val),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .vec_rd(vec_rd), .stk_wr(stk_wr),
    .ctrl_q(ctrl_q), .req(req), .irq_vec(irq_vec), .fiq_vec(fiq_vec),
    .irq_stack(irq_stack), .fiq_stack(fiq_stack)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] idx_of(input logic [31:0] v);
    return v[6:2];
  endfunction

  task automatic set_prio(input int i, input int p);
    src_prio[i*PW +: PW] = PW'(p);
  endtask

  task automatic settle();
    #2;
  endtask

  task automatic strobe(input logic [1:0] rd, input logic [1:0] wr);
    @(negedge clk);
    vec_rd = rd;
    stk_wr = wr;
    @(negedge clk);
    vec_rd = '0;
    stk_wr = '0;
    settle();
  endtask

  task automatic write_ctrl(input logic [1:0] v);
    @(negedge clk);
    ctl_we = 1'b1;
    ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
    settle();
  endtask

  task automatic t_reset();
    check("R1 ctrl after reset", 32'(ctrl_q), 32'h0);
    check("R2 req after reset", 32'(req), 32'h0);
    check("R5 irq stack after reset", 32'(irq_stack), 32'h0);
    check("R9 fiq stack after reset", 32'(fiq_stack), 32'h0);
  endtask

  task automatic t_flat();
    @(negedge clk);
    set_prio(3, 5); set_prio(10, 1);
    src_lvl[3] = 1'b1; src_lvl[10] = 1'b1;
    settle();
    check("R2 irq req raised", 32'(req), 32'h1);
    check("R3 flat winner lowest number", 32'(idx_of(irq_vec)), 32'd3);
    strobe(2'b01, 2'b00);
    check("R5 flat read leaves stack", 32'(irq_stack), 32'h0);
    @(negedge clk);
    src_en[3] = 1'b0;
    settle();
    check("R2 disabled line ignored", 32'(idx_of(irq_vec)), 32'd10);
    @(negedge clk);
    src_en[3] = 1'b1;
    settle();
  endtask

  task automatic t_nest_arb();
    write_ctrl(2'b01);
    check("R1 ctrl write", 32'(ctrl_q), 32'h1);
    check("R4 nested winner by priority", 32'(idx_of(irq_vec)), 32'd10);
    @(negedge clk);
    set_prio(4, 1); set_prio(6, 1);
    src_lvl[4] = 1'b1; src_lvl[6] = 1'b1;
    settle();
    check("R4 tie goes to lowest number", 32'(idx_of(irq_vec)), 32'd4);
    @(negedge clk);
    src_lvl[4] = 1'b0; src_lvl[6] = 1'b0;
    settle();
  endtask

  task automatic t_push_mask();
    strobe(2'b01, 2'b00);
    check("R5 read pushes level 1", 32'(irq_stack), 32'h02);
    check("R6 levels 1 and lower masked", 32'(req), 32'h0);
    @(negedge clk);
    set_prio(12, 0);
    src_lvl[12] = 1'b1;
    settle();
    check("R6 more urgent level passes", 32'(idx_of(irq_vec)), 32'd12);
    check("R6 request back", 32'(req[0]), 32'h1);
    strobe(2'b01, 2'b00);
    check("R5 second push", 32'(irq_stack), 32'h03);
    @(negedge clk);
    src_lvl[12] = 1'b0;
    settle();
  endtask

  task automatic t_pop();
    strobe(2'b00, 2'b01);
    check("R7 pop clears bit 0", 32'(irq_stack), 32'h02);
    strobe(2'b00, 2'b01);
    check("R7 pop clears bit 1", 32'(irq_stack), 32'h00);
    check("R6 unmask restores winner", 32'(idx_of(irq_vec)), 32'd10);
    @(negedge clk);
    src_lvl[3] = 1'b0; src_lvl[10] = 1'b0;
    set_prio(5, 3);
    src_lvl[5] = 1'b1;
    settle();
    strobe(2'b01, 2'b00);
    check("R5 push level 3", 32'(irq_stack), 32'h08);
    @(negedge clk);
    src_lvl[12] = 1'b1;
    settle();
    strobe(2'b01, 2'b00);
    check("R7 stack 0x09 built", 32'(irq_stack), 32'h09);
    strobe(2'b00, 2'b01);
    check("R7 0x09 to 0x08", 32'(irq_stack), 32'h08);
    strobe(2'b01, 2'b01);
    check("R7 pop then push same cycle", 32'(irq_stack), 32'h01);
    strobe(2'b00, 2'b01);
    check("R7 back to empty", 32'(irq_stack), 32'h00);
    @(negedge clk);
    src_lvl[5] = 1'b0; src_lvl[12] = 1'b0;
    settle();
  endtask

  task automatic t_fast();
    @(negedge clk);
    src_fast[8] = 1'b1;
    set_prio(8, 2);
    src_lvl[8] = 1'b1;
    settle();
    check("R9 fast req only", 32'(req), 32'h2);
    check("R8 vector word layout", fiq_vec, 32'h0052_E1A0);
    check("R8 line 8 field", 32'(idx_of(fiq_vec)), 32'h08);
    strobe(2'b10, 2'b00);
    check("R5 fast flat read keeps stack", 32'(fiq_stack), 32'h0);
    write_ctrl(2'b11);
    check("R1 both nest bits", 32'(ctrl_q), 32'h3);
    strobe(2'b10, 2'b00);
    check("R9 fast stack pushed", 32'(fiq_stack), 32'h04);
    check("R9 normal stack untouched", 32'(irq_stack), 32'h00);
    check("R6 fast line masked", 32'(req[1]), 32'h0);
    @(negedge clk);
    src_lvl[10] = 1'b1;
    settle();
    check("R9 normal req unaffected", 32'(req[0]), 32'h1);
    check("R8 normal vector word", irq_vec, 32'h0052_E1A8);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    t_reset();
    t_flat();
    t_nest_arb();
    t_push_mask();
    t_pop();
    t_fast();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule